// File: doc/BRIEF.md
# Load/Store Alignment Fault Checker

This block decides, for one load or store issued at the most privileged execution level, whether the access raises an alignment fault. Three independent rules are evaluated side by side. The first is a natural-alignment rule that requires the address to be a multiple of the element size, and it is gated by a general enable. The second is a stack rule that requires a 16-byte-aligned stack pointer whenever the stack pointer is the base register, and it is gated by a stack-check enable. The third is a window rule for acquire/release-class accesses, which requires every byte of the access to lie in one 16-byte-aligned block. This rule is disabled when the "unaligned permitted" control bit is set, and the general enable has no effect on it.

A request is presented for one cycle with `req_valid`. The verdict appears on registered outputs in the next cycle, together with a small code that tells the trap logic which exception class to raise. A stack fault outranks every other fault. Address translation, the memory access itself and exception entry lie outside the block.

Top module: `ls_align_guard`

## Requirements
- R1: With `ctl_align_en`=1, an access whose address is not a multiple of its size in bytes sets `fault_align`. The size is 2^`acc_size_lg2` bytes, so codes 0 to 4 mean 1, 2, 4, 8 and 16 bytes.
- R2: An access whose address is a multiple of its size does not set `fault_align` through the natural rule. With `ctl_align_en`=0, an access that is not acquire/release class never sets `fault_align`.
- R3: An acquire/release-class access (`is_acqrel`=1) with `ctl_unaligned_ok`=0 sets `fault_align` when address bits [63:4] of its first byte differ from those of its last byte (address + size − 1, taken modulo 2^64). This applies whatever the value of `ctl_align_en`.
- R4: With `ctl_unaligned_ok`=1 the window rule never faults, but the natural rule of R1 still applies.
- R5: `fault_sp` is set when `ctl_sp_align_en`=1, `base_is_sp`=1 and `sp_value[3:0]`≠0. It stays clear if any one of these conditions is absent.
- R6: When the stack fault condition holds, `fault_sp`=1 and `fault_align`=0, even if an alignment condition also holds.
- R7: `fault_code` is 2'd1 (data abort) when `fault_align`=1, 2'd2 (stack alignment) when `fault_sp`=1, and 2'd0 otherwise.
- R8: The outputs are registered. A request sampled at clock edge n is reflected at `rsp_valid`, `fault_align`, `fault_sp` and `fault_code` after edge n. A cycle with `req_valid`=0 produces `rsp_valid`=0 and all fault outputs 0.
- R9: A synchronous active-high `rst` clears `rsp_valid`, both fault flags and `fault_code`.
- R10: `acc_size_lg2` codes 5 to 7 are treated as 16 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| acc_addr | input | 64 | Address of the first byte |
| acc_size_lg2 | input | 3 | log2 of the access size in bytes |
| base_is_sp | input | 1 | Base register is the stack pointer |
| sp_value | input | 64 | Current stack pointer |
| is_acqrel | input | 1 | Access is of the acquire/release class |
| ctl_align_en | input | 1 | General natural-alignment check enable |
| ctl_sp_align_en | input | 1 | Stack pointer alignment check enable |
| ctl_unaligned_ok | input | 1 | Disables the acquire/release 16-byte window check |
| rsp_valid | output | 1 | Verdict valid |
| fault_align | output | 1 | Alignment fault (data abort) |
| fault_sp | output | 1 | Stack alignment fault |
| fault_code | output | 2 | 0 none, 1 data abort, 2 stack alignment |

## Verification
The assertions check several properties on every cycle. The two fault flags are never raised together. The code always agrees with the flags. An idle cycle never yields a fault. A misaligned odd address with the general enable set always faults, and an acquire/release access with the window check disabled and the general enable clear never faults. Only the bench scenarios can show that the window rule fires exactly at a 16-byte boundary, including address wraparound at the top of the space. The same holds for the saturation of oversized size codes, for the reset values, and for each disabled enable masking its own rule.

// File: rtl/ls_align_pkg.sv
package ls_align_pkg;
  localparam int ADDR_W   = 64;
  localparam int SIZE_W   = 3;
  localparam int MAX_LG2  = 4;
  localparam int WIN_LG2  = 4;
  localparam int SP_LG2   = 4;
  localparam int CODE_W   = 2;

  typedef enum logic [CODE_W-1:0] {
    FC_NONE     = 2'd0,
    FC_DABT     = 2'd1,
    FC_SP_ALIGN = 2'd2
  } fault_code_e;
endpackage

// File: rtl/natural_align_chk.sv
module natural_align_chk #(
  parameter int AW   = 64,
  parameter int SZW  = 3,
  parameter int MAXL = 4
) (
  input  logic [AW-1:0]  addr,
  input  logic [SZW-1:0] lg2,
  output logic           misaligned
);
  logic [MAXL-1:0] bit_bad;
  for (genvar i = 0; i < MAXL; i++) begin : g_bit
    assign bit_bad[i] = addr[i] && (lg2 > SZW'(i));
  end
  assign misaligned = |bit_bad;
endmodule

// File: rtl/sp_align_chk.sv
module sp_align_chk #(
  parameter int AW  = 64,
  parameter int SPL = 4
) (
  input  logic [AW-1:0] sp,
  input  logic          enable,
  input  logic          uses_sp,
  output logic          sp_bad
);
  assign sp_bad = enable && uses_sp && (|sp[SPL-1:0]);
endmodule

// File: rtl/window_chk.sv
module window_chk #(
  parameter int AW   = 64,
  parameter int SZW  = 3,
  parameter int WINL = 4
) (
  input  logic [AW-1:0]  addr,
  input  logic [SZW-1:0] lg2,
  output logic           crosses
);
  logic [AW-1:0] span_m1;
  logic [AW-1:0] last_byte;
  assign span_m1   = (AW'(1) << lg2) - AW'(1);
  assign last_byte = addr + span_m1;
  assign crosses   = addr[AW-1:WINL] != last_byte[AW-1:WINL];
endmodule

// File: rtl/ls_align_guard.sv
module ls_align_guard
  import ls_align_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int SZW  = SIZE_W,
  parameter int MAXL = MAX_LG2,
  parameter int WINL = WIN_LG2,
  parameter int SPL  = SP_LG2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [AW-1:0]     acc_addr,
  input  logic [SZW-1:0]    acc_size_lg2,
  input  logic              base_is_sp,
  input  logic [AW-1:0]     sp_value,
  input  logic              is_acqrel,
  input  logic              ctl_align_en,
  input  logic              ctl_sp_align_en,
  input  logic              ctl_unaligned_ok,
  output logic              rsp_valid,
  output logic              fault_align,
  output logic              fault_sp,
  output logic [CODE_W-1:0] fault_code
);
  localparam logic [SZW-1:0] LG2_CAP = SZW'(MAXL);

  logic [SZW-1:0] eff_lg2;
  logic nat_bad, sp_bad, win_bad;
  logic align_hit, sp_hit;

  // R10: oversize codes saturate to the largest element
  assign eff_lg2 = (acc_size_lg2 > LG2_CAP) ? LG2_CAP : acc_size_lg2;

  natural_align_chk #(.AW(AW), .SZW(SZW), .MAXL(MAXL)) u_nat (
    .addr(acc_addr), .lg2(eff_lg2), .misaligned(nat_bad));

  sp_align_chk #(.AW(AW), .SPL(SPL)) u_sp (
    .sp(sp_value), .enable(ctl_sp_align_en), .uses_sp(base_is_sp), .sp_bad(sp_bad));

  window_chk #(.AW(AW), .SZW(SZW), .WINL(WINL)) u_win (
    .addr(acc_addr), .lg2(eff_lg2), .crosses(win_bad));

  // R1..R4 alignment sources, R6 stack priority
  assign sp_hit    = req_valid && sp_bad;
  assign align_hit = req_valid && !sp_bad &&
                     ((ctl_align_en && nat_bad) ||
                      (is_acqrel && !ctl_unaligned_ok && win_bad));

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      fault_align <= 1'b0;
      fault_sp    <= 1'b0;
      fault_code  <= FC_NONE;
    end else begin
      rsp_valid   <= req_valid;
      fault_align <= align_hit;
      fault_sp    <= sp_hit;
      if (sp_hit)         fault_code <= FC_SP_ALIGN;
      else if (align_hit) fault_code <= FC_DABT;
      else                fault_code <= FC_NONE;
    end
  end

  p_sp_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(fault_sp && fault_align));

  p_code_dabt_r7: assert property (@(posedge clk) disable iff (rst)
    fault_align |-> fault_code == FC_DABT);

  p_code_sp_r7: assert property (@(posedge clk) disable iff (rst)
    fault_sp |-> fault_code == FC_SP_ALIGN);

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!fault_align && !fault_sp && !rsp_valid));

  p_odd_faults_r1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && ctl_align_en && acc_addr[0] && acc_size_lg2 != '0 &&
     !(ctl_sp_align_en && base_is_sp && |sp_value[SPL-1:0])) |=> fault_align);

  p_window_off_r4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && is_acqrel && ctl_unaligned_ok && !ctl_align_en) |=> !fault_align);
endmodule

// File: tb/ls_align_guard_tb_top.sv
module ls_align_guard_tb_top;
  typedef struct packed {
    logic [63:0] addr;
    logic [2:0]  sz;
    logic        spb;
    logic [63:0] sp;
    logic        ar;
    logic        a;
    logic        sa;
    logic        naa;
    logic        ea;
    logic        es;
    logic [1:0]  ec;
    logic [7:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{64'h1001, 3'd1, 1'b0, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 8'd1},  // R1
    '{64'h1008, 3'd3, 1'b0, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd2},  // R2
    '{64'h1004, 3'd3, 1'b0, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 8'd1},  // R1
    '{64'h1003, 3'd0, 1'b0, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd2},  // R2
    '{64'h1003, 3'd2, 1'b0, 64'h0,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd2},  // R2
    '{64'h100C, 3'd3, 1'b0, 64'h0,    1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 8'd3},  // R3
    '{64'h1004, 3'd3, 1'b0, 64'h0,    1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3},  // R3
    '{64'h100C, 3'd3, 1'b0, 64'h0,    1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'd4},  // R4
    '{64'h100F, 3'd0, 1'b0, 64'h0,    1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3},  // R3
    '{64'h2008, 3'd3, 1'b1, 64'h2008, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 8'd5},  // R5
    '{64'h2010, 3'd3, 1'b1, 64'h2010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd5},  // R5
    '{64'h2008, 3'd3, 1'b1, 64'h2008, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd5},  // R5
    '{64'h2008, 3'd3, 1'b0, 64'h2008, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd5},  // R5
    '{64'h2001, 3'd3, 1'b1, 64'h2008, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 2'd2, 8'd6},  // R6
    '{64'h1008, 3'd5, 1'b0, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 8'd10}, // R10
    '{64'h1010, 3'd7, 1'b0, 64'h0,    1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd10}, // R10
    '{64'hFFFF_FFFF_FFFF_FFF8, 3'd4, 1'b0, 64'h0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd1, 8'd3}, // R3 wrap
    '{64'h1004, 3'd3, 1'b0, 64'h0,    1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 8'd4}   // R4 with R1
  };

  logic clk = 1'b0;
  logic rst;
  logic req_valid;
  logic [63:0] acc_addr, sp_value;
  logic [2:0] acc_size_lg2;
  logic base_is_sp, is_acqrel, ctl_align_en, ctl_sp_align_en, ctl_unaligned_ok;
  logic rsp_valid, fault_align, fault_sp;
  logic [1:0] fault_code;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  ls_align_guard dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .acc_addr(acc_addr),
    .acc_size_lg2(acc_size_lg2), .base_is_sp(base_is_sp), .sp_value(sp_value),
    .is_acqrel(is_acqrel), .ctl_align_en(ctl_align_en),
    .ctl_sp_align_en(ctl_sp_align_en), .ctl_unaligned_ok(ctl_unaligned_ok),
    .rsp_valid(rsp_valid), .fault_align(fault_align), .fault_sp(fault_sp),
    .fault_code(fault_code));

  task automatic check(input string req, input logic [4:0] got, input logic [4:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: {valid,align,sp,code} got %b expected %b", req, got, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    req_valid        = vld;
    acc_addr         = v.addr;
    acc_size_lg2     = v.sz;
    base_is_sp       = v.spb;
    sp_value         = v.sp;
    is_acqrel        = v.ar;
    ctl_align_en     = v.a;
    ctl_sp_align_en  = v.sa;
    ctl_unaligned_ok = v.naa;
  endtask

  initial begin
    #200000;
    n_errors++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    drive(VECS[0], 1'b1);
    repeat (3) @(negedge clk);
    // R9: reset holds outputs clear while a faulting request is present
    check("R9", {rsp_valid, fault_align, fault_sp, fault_code}, 5'b0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i], 1'b1);
      @(negedge clk);
      check($sformatf("R%0d vec%0d", VECS[i].rq, i),
            {rsp_valid, fault_align, fault_sp, fault_code},
            {1'b1, VECS[i].ea, VECS[i].es, VECS[i].ec});
    end

    // R8: idle cycle with faulting inputs yields nothing
    drive(VECS[13], 1'b0);
    @(negedge clk);
    check("R8 idle", {rsp_valid, fault_align, fault_sp, fault_code}, 5'b0);

    // R8: one-cycle latency, verdict not visible before the edge
    drive(VECS[0], 1'b1);
    #1;
    check("R8 latency before edge", {rsp_valid, fault_align, fault_sp, fault_code}, 5'b0);
    @(negedge clk);
    check("R8 latency after edge", {rsp_valid, fault_align, fault_sp, fault_code}, 5'b11001);

    // R9: reset mid-stream clears a pending fault
    drive(VECS[9], 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R9 mid", {rsp_valid, fault_align, fault_sp, fault_code}, 5'b0);
    rst = 1'b0;
    drive(VECS[1], 1'b0);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule